// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block keeps the per-CPU bookkeeping of which interrupt is being serviced. When the CPU acknowledges, the block compares the highest pending interrupt, supplied by an external arbiter as an ID and an 8-bit priority, against the priority of the interrupt already being serviced. If the pending one is strictly more urgent (a numerically smaller value), the block returns its ID, sends a one-cycle clear pulse for that interrupt's pending state, makes it the running interrupt and records the interrupt it pre-empted. Otherwise it returns the spurious ID 1023 and changes nothing.

The record of pre-empted interrupts is a linked list held in a memory indexed by interrupt ID: each entry names the interrupt that was running when that ID was taken. A completion of the running interrupt pops the list. A completion of an interrupt buried deeper in the list starts a walk that visits one link per clock and unlinks the buried entry, leaving the running interrupt untouched. While a walk is in progress both request channels are held off.

Both requests use valid/ready. An acknowledge is taken on a clock edge where `ack_valid` and `ack_ready` are high; its answer appears as a one-cycle `rsp_valid` pulse after that edge and cannot be stalled. A completion is taken where `eoi_valid` and `eoi_ready` are high. `ack_ready` is low only during a walk; `eoi_ready` is also low while `ack_valid` is high, so an acknowledge wins a tie. A requester holds valid and its data until it sees ready.

Top module: `irq_ack_tracker`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0x100, both ready outputs are high, and `rsp_valid` and `clr_valid` are low.
- R2: An accepted acknowledge whose pending ID is 1023 or not below NUM_IRQ, or whose pending priority is numerically greater than or equal to the running priority, gives `rsp_id` 1023 with no clear pulse and no change of the running ID.
- R3: An accepted acknowledge that passes the test of R2 gives, one cycle after the handshake edge, `rsp_id` and `clr_id` equal to the pending ID with `clr_valid` high, the running ID equal to that ID and the running priority equal to its acknowledged priority with a zero ninth bit.
- R4: While the running ID is 1023 the 9-bit running priority reads 0x100.
- R5: The completion ID is bits 9..0 of `eoi_data`; bits 31..10 are ignored. A completion ID at or above NUM_IRQ, including 1023, changes no state and starts no walk.
- R6: A completion while the running ID is 1023 changes no state and starts no walk.
- R7: Completing the running interrupt makes the interrupt it pre-empted the running one, in the cycle after the handshake.
- R8: Completing an interrupt that is in the chain below the running one leaves the running ID unchanged and removes that interrupt from the chain, so later completions of the running interrupts skip it.
- R9: A completion of a non-running ID holds both ready outputs low for one cycle per link visited; a walk that reaches 1023 without finding the ID ends with no change.
- R10: When `ack_valid` and `eoi_valid` are both high, `eoi_ready` is low and the acknowledge is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_id | input | 10 | Highest pending interrupt ID from the arbiter, 1023 for none |
| pend_prio | input | PRIO_W | Priority of `pend_id`, smaller is more urgent |
| ack_valid | input | 1 | Acknowledge request |
| ack_ready | output | 1 | Acknowledge can be taken (no walk in progress) |
| rsp_valid | output | 1 | One-cycle pulse carrying the acknowledge answer |
| rsp_id | output | 10 | Acknowledged ID or 1023 |
| eoi_valid | input | 1 | Completion request |
| eoi_ready | output | 1 | Completion can be taken |
| eoi_data | input | 32 | Completion word, ID in bits 9..0 |
| clr_valid | output | 1 | One-cycle pulse: clear pending state of `clr_id` |
| clr_id | output | 10 | Interrupt whose pending state is to be cleared |
| run_id | output | 10 | Running interrupt ID, 1023 for none |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |

## Verification
A corrupted link entry stays hidden until the chain is unwound: the running ID and priority look right, and the fault shows only when a later completion pops to the wrong ID or when a walk fails to find or unlink a buried interrupt, so the bench builds nested chains three deep and unwinds them fully, checking `run_id` after every completion. A wrong running priority shows at the very next acknowledge as a wrong grant or refusal, which is why the bench offers equal and better priorities against each running level. Walk control errors appear as ready outputs that stay low too long or too briefly, checked in the cycle after the completion edge.

// File: rtl/iat_pkg.sv
package iat_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

  typedef enum logic {
    WK_IDLE,
    WK_SCAN
  } walk_state_t;
endpackage

// File: rtl/iat_link_store.sv
module iat_link_store
  import iat_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned NRD     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ID_W-1:0]          wr_idx,
  input  logic [ID_W-1:0]          wr_link,
  input  logic                     wr_prio_en,
  input  logic [PRIO_W-1:0]        wr_prio,
  input  logic [NRD-1:0][ID_W-1:0] rd_idx,
  output logic [NRD-1:0][ID_W-1:0] rd_link,
  output logic [PRIO_W-1:0]        rd0_prio
);
  localparam int unsigned IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

  logic [ID_W-1:0]   link_q [NUM_IRQ];
  logic [PRIO_W-1:0] prio_q [NUM_IRQ];

  wire wr_hit = wr_idx < LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        link_q[i] <= NO_IRQ;
        prio_q[i] <= '0;
      end
    end else if (wr_hit) begin
      if (wr_en)      link_q[wr_idx[IDX_W-1:0]] <= wr_link;
      if (wr_prio_en) prio_q[wr_idx[IDX_W-1:0]] <= wr_prio;
    end
  end

  // Out-of-range reads (including 1023) see an empty link.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_link[p] = (rd_idx[p] < LIMIT) ? link_q[rd_idx[p][IDX_W-1:0]] : NO_IRQ;
  end

  assign rd0_prio = (rd_idx[0] < LIMIT) ? prio_q[rd_idx[0][IDX_W-1:0]] : '0;
endmodule

// File: rtl/iat_grant.sv
module iat_grant
  import iat_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned PRIO_W  = 8
) (
  input  logic [ID_W-1:0]   pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W:0]   run_prio,
  output logic              grant
);
  localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

  always_comb begin
    grant = (pend_id != NO_IRQ) && (pend_id < LIMIT)
            && ({1'b0, pend_prio} < run_prio);
  end
endmodule

// File: rtl/iat_chain_walker.sv
module iat_chain_walker
  import iat_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ID_W-1:0] start_idx,
  input  logic [ID_W-1:0] target,
  input  logic [ID_W-1:0] cur_link,
  input  logic [ID_W-1:0] tgt_link,
  output logic            busy,
  output logic [ID_W-1:0] cur_idx,
  output logic [ID_W-1:0] tgt_idx,
  output logic            splice_en,
  output logic [ID_W-1:0] splice_idx,
  output logic [ID_W-1:0] splice_link
);
  localparam int unsigned SW = $clog2(NUM_IRQ + 1);
  localparam logic [SW-1:0] MAX_STEPS = SW'(NUM_IRQ);

  walk_state_t     st_q;
  logic [ID_W-1:0] cur_q, tgt_q;
  logic [SW-1:0]   step_q;

  wire at_end   = (cur_link == NO_IRQ);
  wire at_match = (cur_link == tgt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      cur_q  <= NO_IRQ;
      tgt_q  <= NO_IRQ;
      step_q <= '0;
    end else begin
      case (st_q)
        WK_IDLE: if (start) begin
          st_q   <= WK_SCAN;
          cur_q  <= start_idx;
          tgt_q  <= target;
          step_q <= '0;
        end
        WK_SCAN: begin
          step_q <= step_q + 1'b1;
          if (at_end || at_match) st_q <= WK_IDLE;
          else                    cur_q <= cur_link;
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign busy        = (st_q == WK_SCAN);
  assign cur_idx     = cur_q;
  assign tgt_idx     = tgt_q;
  assign splice_en   = busy && !at_end && at_match;
  assign splice_idx  = cur_q;
  assign splice_link = tgt_link;

  // R9: a walk never visits more links than there are interrupts.
  a_r9_walk_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_q < MAX_STEPS));

  // R8: a splice ends the walk at the next edge.
  a_r8_splice_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    splice_en |=> !busy);

  // R9: a walk that reaches the end of the chain writes nothing.
  a_r9_end_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_link == NO_IRQ) |-> !splice_en);
endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
  import iat_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned PRIO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [9:0]        pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              ack_valid,
  output logic              ack_ready,
  output logic              rsp_valid,
  output logic [9:0]        rsp_id,
  input  logic              eoi_valid,
  output logic              eoi_ready,
  input  logic [31:0]       eoi_data,
  output logic              clr_valid,
  output logic [9:0]        clr_id,
  output logic [9:0]        run_id,
  output logic [PRIO_W:0]   run_prio
);
  localparam int unsigned NRD = 3;
  localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  logic [ID_W-1:0] run_q;
  logic [ID_W-1:0] rsp_q, clr_id_q;
  logic            rsp_v_q, clr_v_q;

  logic [NRD-1:0][ID_W-1:0] rd_idx, rd_link;
  logic [PRIO_W-1:0]        rd0_prio;

  logic            walk_busy, splice_en;
  logic [ID_W-1:0] walk_cur, walk_tgt, splice_idx, splice_link;
  logic            grant;

  // Request acceptance
  assign ack_ready = !walk_busy;
  assign eoi_ready = !walk_busy && !ack_valid;
  wire ack_fire = ack_valid && ack_ready;
  wire eoi_fire = eoi_valid && eoi_ready;
  wire ack_take = ack_fire && grant;

  // Completion decode: only the low ID_W bits carry the ID.
  wire [ID_W-1:0] eoi_id = eoi_data[ID_W-1:0];
  logic unused_eoi_hi;
  assign unused_eoi_hi = ^eoi_data[31:ID_W];

  wire eoi_live   = eoi_fire && (eoi_id < LIMIT) && (run_q != NO_IRQ);
  wire eoi_is_run = (eoi_id == run_q);
  wire walk_start = eoi_live && !eoi_is_run;
  wire pop_run    = eoi_live && eoi_is_run;

  assign run_prio = (run_q == NO_IRQ) ? IDLE_PRIO : {1'b0, rd0_prio};

  iat_grant #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_grant (
    .pend_id  (pend_id),
    .pend_prio(pend_prio),
    .run_prio (run_prio),
    .grant    (grant)
  );

  assign rd_idx[0] = run_q;
  assign rd_idx[1] = walk_cur;
  assign rd_idx[2] = walk_tgt;

  // One write port: the acknowledge and the splice never coincide, since a
  // walk holds ack_ready low.
  iat_link_store #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .NRD(NRD)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ack_take || splice_en),
    .wr_idx    (ack_take ? pend_id : splice_idx),
    .wr_link   (ack_take ? run_q : splice_link),
    .wr_prio_en(ack_take),
    .wr_prio   (pend_prio),
    .rd_idx    (rd_idx),
    .rd_link   (rd_link),
    .rd0_prio  (rd0_prio)
  );

  iat_chain_walker #(.NUM_IRQ(NUM_IRQ)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (walk_start),
    .start_idx  (run_q),
    .target     (eoi_id),
    .cur_link   (rd_link[1]),
    .tgt_link   (rd_link[2]),
    .busy       (walk_busy),
    .cur_idx    (walk_cur),
    .tgt_idx    (walk_tgt),
    .splice_en  (splice_en),
    .splice_idx (splice_idx),
    .splice_link(splice_link)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= NO_IRQ;
      rsp_v_q  <= 1'b0;
      rsp_q    <= NO_IRQ;
      clr_v_q  <= 1'b0;
      clr_id_q <= NO_IRQ;
    end else begin
      rsp_v_q <= ack_fire;
      clr_v_q <= ack_take;
      if (ack_fire) rsp_q <= grant ? pend_id : NO_IRQ;
      if (ack_take) begin
        clr_id_q <= pend_id;
        run_q    <= pend_id;
      end else if (pop_run) begin
        run_q <= rd_link[0];
      end
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_id    = rsp_q;
  assign clr_valid = clr_v_q;
  assign clr_id    = clr_id_q;
  assign run_id    = run_q;

  // R2: a refused acknowledge answers 1023 and keeps the running ID.
  a_r2_refuse_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !grant) |=> (rsp_valid && rsp_id == NO_IRQ && !clr_valid
                              && $stable(run_id)));

  // R3: a granted acknowledge clears and runs the pending ID.
  a_r3_grant_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && grant) |=> (clr_valid && clr_id == $past(pend_id)
                             && run_id == $past(pend_id)));

  // R3: running priority follows the stored priority of the new interrupt.
  a_r3_prio_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && grant) |=> (run_prio == {1'b0, $past(pend_prio)}));

  // R5, R6: an ignored completion changes nothing and starts no walk.
  a_r5_eoi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !eoi_live) |=> ($stable(run_id) && ack_ready));

  // R9: the running interrupt is frozen while a walk is in progress.
  a_r9_run_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |=> $stable(run_id));

  // R10: no completion is taken while an acknowledge is offered.
  a_r10_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !eoi_fire);
endmodule

// File: tb/test_irq_ack_tracker.sv
module test_irq_ack_tracker;
  localparam int NUM_IRQ = 64;
  localparam int PRIO_W  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  pend_id = 10'd1023;
  logic [7:0]  pend_prio = 8'hff;
  logic        ack_valid = 1'b0;
  logic        ack_ready;
  logic        rsp_valid;
  logic [9:0]  rsp_id;
  logic        eoi_valid = 1'b0;
  logic        eoi_ready;
  logic [31:0] eoi_data = '0;
  logic        clr_valid;
  logic [9:0]  clr_id;
  logic [9:0]  run_id;
  logic [8:0]  run_prio;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  irq_ack_tracker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) i_irq_ack_tracker (
    .clk(clk), .rst_n(rst_n), .pend_id(pend_id), .pend_prio(pend_prio),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .rsp_valid(rsp_valid),
    .rsp_id(rsp_id), .eoi_valid(eoi_valid), .eoi_ready(eoi_ready),
    .eoi_data(eoi_data), .clr_valid(clr_valid), .clr_id(clr_id),
    .run_id(run_id), .run_prio(run_prio)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Acknowledge; expect answer exp_rsp and running ID/priority afterwards.
  task automatic do_ack(input int id, input int pr, input int exp_rsp,
                        input int exp_run, input int exp_prio, input string req);
    @(negedge clk);
    pend_id = 10'(id); pend_prio = 8'(pr); ack_valid = 1'b1;
    chk(ack_ready == 1'b1, {req, " ack_ready"}, int'(ack_ready), 1);
    @(posedge clk);
    @(negedge clk);
    ack_valid = 1'b0;
    chk(rsp_valid == 1'b1, {req, " rsp_valid"}, int'(rsp_valid), 1);
    chk(int'(rsp_id) == exp_rsp, {req, " rsp_id"}, int'(rsp_id), exp_rsp);
    chk(clr_valid == (exp_rsp != 1023), {req, " clr_valid"}, int'(clr_valid),
        int'(exp_rsp != 1023));
    if (exp_rsp != 1023)
      chk(int'(clr_id) == exp_rsp, {req, " clr_id"}, int'(clr_id), exp_rsp);
    chk(int'(run_id) == exp_run, {req, " run_id"}, int'(run_id), exp_run);
    chk(int'(run_prio) == exp_prio, {req, " run_prio"}, int'(run_prio), exp_prio);
  endtask

  // Completion; exp_busy is the number of cycles ready must stay low.
  task automatic do_eoi(input logic [31:0] data, input int exp_busy,
                        input int exp_run, input string req);
    int busy_cnt;
    @(negedge clk);
    eoi_data = data; eoi_valid = 1'b1;
    chk(eoi_ready == 1'b1, {req, " eoi_ready"}, int'(eoi_ready), 1);
    @(posedge clk);
    @(negedge clk);
    eoi_valid = 1'b0;
    busy_cnt = 0;
    for (int k = 0; k < 200 && !ack_ready; k++) begin
      busy_cnt++;
      @(negedge clk);
    end
    chk(busy_cnt == exp_busy, {req, " busy cycles"}, busy_cnt, exp_busy);
    chk(int'(run_id) == exp_run, {req, " run_id"}, int'(run_id), exp_run);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(run_id == 10'd1023, "R1 run_id", int'(run_id), 1023);
    chk(run_prio == 9'h100, "R1 run_prio", int'(run_prio), 256);
    chk(ack_ready && eoi_ready, "R1 ready", int'(ack_ready && eoi_ready), 1);
    chk(!rsp_valid && !clr_valid, "R1 pulses", int'(rsp_valid || clr_valid), 0);
  endtask

  task automatic t_refuse_idle();
    do_ack(1023, 8'h00, 1023, 1023, 256, "R2 spurious pending");
    do_ack(100, 8'h00, 1023, 1023, 256, "R2 id out of range");
  endtask

  task automatic t_nest();
    do_ack(10, 8'h40, 10, 10, 8'h40, "R3 first ack");
    do_ack(20, 8'h40, 1023, 10, 8'h40, "R2 equal priority");
    do_ack(20, 8'h20, 20, 20, 8'h20, "R3 nested ack");
    do_ack(30, 8'h10, 30, 30, 8'h10, "R3 third level");
  endtask

  task automatic t_eoi_ignored_range();
    do_eoi(32'd1023, 0, 30, "R5 spurious eoi");
    do_eoi(32'd64, 0, 30, "R5 id out of range");
    // Upper bits set, low 10 bits = 30: completes the running interrupt.
    do_eoi(32'h5A5A_0000 | 32'd30, 0, 20, "R5 low bits R7 pop");
    chk(run_prio == 9'h020, "R7 prio after pop", int'(run_prio), 32);
  endtask

  task automatic t_out_of_order();
    do_ack(40, 8'h08, 40, 40, 8'h08, "R3 ack 40");
    // Chain 40 -> 20 -> 10; completing 10 visits links at 40 and 20.
    do_eoi(32'd10, 2, 40, "R8 buried eoi");
    chk(run_prio == 9'h008, "R8 prio kept", int'(run_prio), 8);
    do_eoi(32'd40, 0, 20, "R7 pop 40");
    do_eoi(32'd20, 0, 1023, "R8 10 unlinked");
    chk(run_prio == 9'h100, "R4 idle prio", int'(run_prio), 256);
  endtask

  task automatic t_not_found();
    do_ack(5, 8'h01, 5, 5, 1, "R3 ack 5");
    do_eoi(32'd7, 1, 5, "R9 walk miss");
    do_eoi(32'd5, 0, 1023, "R7 pop to idle");
    do_eoi(32'd5, 0, 1023, "R6 eoi while idle");
    do_ack(6, 8'hfe, 6, 6, 8'hfe, "R6 chain intact after idle eoi");
    do_eoi(32'd6, 0, 1023, "R7 pop 6");
  endtask

  task automatic t_tie();
    @(negedge clk);
    pend_id = 10'd3; pend_prio = 8'h02; ack_valid = 1'b1;
    eoi_data = 32'd3; eoi_valid = 1'b1;
    #1;
    chk(eoi_ready == 1'b0, "R10 eoi_ready low", int'(eoi_ready), 0);
    @(posedge clk);
    @(negedge clk);
    ack_valid = 1'b0;
    #1;
    chk(run_id == 10'd3, "R10 ack taken", int'(run_id), 3);
    chk(eoi_ready == 1'b1, "R10 eoi_ready back", int'(eoi_ready), 1);
    @(posedge clk);
    @(negedge clk);
    eoi_valid = 1'b0;
    chk(run_id == 10'd1023, "R10 eoi taken after", int'(run_id), 1023);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_refuse_idle();
    t_nest();
    t_eoi_ignored_range();
    t_out_of_order();
    t_not_found();
    t_tie();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule